// File: doc/BRIEF.md
# Keyboard Event Encoder and Host Command Responder

This block sits behind one serial channel and plays the keyboard. Key events enter on a valid/ready stream as a 7-bit device keycode plus a release flag, and are queued as single bytes in a 256-byte receive FIFO. A press is queued as the bare code. A release is queued as the code with its top bit set. The host reads the FIFO through a byte-available flag, a data output and a pop strobe.

Bytes the host sends to the keyboard arrive on a second valid/ready stream and are treated as commands. A reset command and a layout query each flush the FIFO and queue a fixed reply. An LED command makes the next host byte a parameter, which is dropped without being decoded. Any other byte is ignored. The caps-lock and num-lock keys are filtered to behave like toggle keys. The host sees the press on the first physical press and the release on the second physical release.

Back-pressure works as follows. `cmd_ready` is low while a reply is being queued. `key_ready` is low while a reply is being queued and in any cycle where `cmd_valid` is high, so a command always wins over a key event in the same cycle. A source keeps valid and its payload stable until ready is seen at a rising edge. The FIFO side has no back-pressure, because a byte pushed into a full FIFO is dropped.

Top module: `kbd_cmd_encoder`

## Requirements
- R1: An accepted key event on a non-lock code pushes one byte at that clock edge. A press pushes `{1'b0, code}` and a release pushes `{1'b1, code}`.
- R2: Each lock key (codes 119 and 98) keeps a 2-bit state that starts at 0. A press XORs it with 1 and is dropped if the new state is 2. A release XORs it with 2 and is dropped if the new state is 3.
- R3: Host byte 0x01 flushes the FIFO at its accepting edge. It then pushes 0xFF, 0x04 and 0x7F, one byte on each of the next three edges.
- R4: Host byte 0x0E arms a parameter state. The next processed host byte is discarded whatever its value, and that byte clears the state.
- R5: Host bytes 0x07 and 0x0F each flush the FIFO and then push 0xFE and 0x21, one byte per edge.
- R6: Any other processed host byte leaves the FIFO contents unchanged.
- R7: A host byte accepted while `tx_enable` is low or `kbd_disable` is high has no effect. This includes the LED parameter state.
- R8: The FIFO holds 256 bytes, and a push while it is full is dropped. `rx_data` shows the oldest byte while `rx_avail` is high and shows 0 when the FIFO is empty. A pop from an empty FIFO changes nothing.
- R9: `key_ready` is low while a reply is being queued and whenever `cmd_valid` is high. A held key event is queued after the whole reply, so bytes are never interleaved.
- R10: After reset the FIFO is empty, `rx_data` is 0, and both ready outputs are high when `cmd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | Key event valid |
| key_ready | output | 1 | Key event accepted at this edge |
| key_code | input | 7 | Device keycode |
| key_release | input | 1 | 1 = release, 0 = press |
| cmd_valid | input | 1 | Host byte valid |
| cmd_ready | output | 1 | Host byte accepted at this edge |
| cmd_data | input | 8 | Host command or parameter byte |
| tx_enable | input | 1 | Channel transmit enable; host bytes are processed only when high |
| kbd_disable | input | 1 | Keyboard disabled; host bytes are ignored when high |
| rx_avail | output | 1 | FIFO holds at least one byte |
| rx_data | output | 8 | Oldest FIFO byte, 0 when empty |
| rx_pop | input | 1 | Remove the oldest byte at this edge |

## Verification
Random key streams mix ordinary codes with frequent lock-key presses and releases. The lock presses separate the four-state toggle filter from plain pass-through, and the release bit separates make codes from break codes. Directed sequences cover the following: each reply command issued into a non-empty FIFO, which shows that the flush happens before the reply; an LED command followed by a reset byte, which must be swallowed; and commands sent with transmit disabled or the keyboard disabled. A command and a key event are presented in the same cycle to show that the reply is not interleaved. The FIFO is filled past 256 entries and popped while empty to exercise both ends of its range.

// File: rtl/kbd_enc_pkg.sv
package kbd_enc_pkg;
  typedef enum logic [1:0] {REP_NONE, REP_IDENT, REP_LAYOUT} reply_e;

  localparam logic [7:0] HC_RESET   = 8'h01;
  localparam logic [7:0] HC_LED     = 8'h0E;
  localparam logic [7:0] HC_LAYOUT0 = 8'h07;
  localparam logic [7:0] HC_LAYOUT1 = 8'h0F;

  function automatic logic [1:0] reply_len(reply_e kind);
    case (kind)
      REP_IDENT:  return 2'd3;
      REP_LAYOUT: return 2'd2;
      default:    return 2'd0;
    endcase
  endfunction

  function automatic logic [7:0] reply_byte(reply_e kind, logic [1:0] idx);
    if (kind == REP_IDENT) begin
      case (idx)
        2'd0:    return 8'hFF;
        2'd1:    return 8'h04;
        default: return 8'h7F;
      endcase
    end else begin
      return (idx == 2'd0) ? 8'hFE : 8'h21;
    end
  endfunction
endpackage

// File: rtl/kbd_byte_fifo.sv
module kbd_byte_fifo #(
  parameter int DEPTH = 256,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          avail,
  output logic [DW-1:0] head
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic          full, do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign avail   = (count != '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && avail && !flush;
  assign head    = avail ? mem[rptr] : '0;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  a_r8_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (count == (AW+1)'(DEPTH)));
  a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (!avail && pop && !push && !flush) |=> !avail);
endmodule

// File: rtl/kbd_lock_filter.sv
module kbd_lock_filter #(
  parameter int                          CODE_W    = 7,
  parameter int                          NUM_LOCKS = 2,
  parameter logic [NUM_LOCKS*CODE_W-1:0] LOCK_CODES = {7'd98, 7'd119}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_fire,
  input  logic [CODE_W-1:0] ev_code,
  input  logic              ev_release,
  output logic              drop
);
  logic [NUM_LOCKS-1:0] hit, drp;

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    logic [1:0] st, nxt;
    assign hit[g] = (ev_code == LOCK_CODES[g*CODE_W +: CODE_W]);
    assign nxt    = st ^ (ev_release ? 2'b10 : 2'b01);
    assign drp[g] = hit[g] && (ev_release ? (nxt == 2'b11) : (nxt == 2'b10));
    always_ff @(posedge clk) begin
      if (!rst_n)                st <= 2'b00;
      else if (ev_fire && hit[g]) st <= nxt;
    end
  end

  assign drop = |drp;

  a_r2_drop_only_locks: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> (|hit));
endmodule

// File: rtl/kbd_cmd_seq.sv
module kbd_cmd_seq
  import kbd_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_data,
  input  logic       tx_enable,
  input  logic       kbd_disable,
  output logic       busy,
  output logic       flush,
  output logic       push,
  output logic [7:0] push_data
);
  reply_e     kind;
  logic [1:0] idx;
  logic       led_mode, accept, act, is_reply;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign act       = accept && tx_enable && !kbd_disable;
  assign is_reply  = (cmd_data == HC_RESET) || (cmd_data == HC_LAYOUT0) ||
                     (cmd_data == HC_LAYOUT1);
  assign flush     = act && !led_mode && is_reply;
  assign push      = busy;
  assign push_data = reply_byte(kind, idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      led_mode <= 1'b0;
      kind     <= REP_NONE;
      idx      <= '0;
    end else if (act) begin
      if (led_mode) begin
        led_mode <= 1'b0;
      end else if (cmd_data == HC_LED) begin
        led_mode <= 1'b1;
      end else if (is_reply) begin
        busy <= 1'b1;
        idx  <= '0;
        kind <= (cmd_data == HC_RESET) ? REP_IDENT : REP_LAYOUT;
      end
    end else if (busy) begin
      idx <= idx + 1'b1;
      if (idx == reply_len(kind) - 2'd1) busy <= 1'b0;
    end
  end

  a_r3_flush_starts_reply: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (push && idx == 2'd0));
  a_r4_param_swallowed: assert property (@(posedge clk) disable iff (!rst_n)
    (act && led_mode) |=> (!busy && !led_mode));
  a_r7_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(tx_enable && !kbd_disable)) |=> ($stable(led_mode) && !busy));
endmodule

// File: rtl/kbd_cmd_encoder.sv
module kbd_cmd_encoder #(
  parameter int CODE_W     = 7,
  parameter int FIFO_DEPTH = 256,
  parameter int CAPS_CODE  = 119,
  parameter int NUM_CODE   = 98
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  output logic              key_ready,
  input  logic [CODE_W-1:0] key_code,
  input  logic              key_release,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_data,
  input  logic              tx_enable,
  input  logic              kbd_disable,
  output logic              rx_avail,
  output logic [CODE_W:0]   rx_data,
  input  logic              rx_pop
);
  localparam int BW = CODE_W + 1;

  logic          seq_busy, seq_flush, seq_push, key_fire, key_drop, key_push;
  logic [7:0]    seq_data;
  logic [BW-1:0] push_data;

  assign key_ready = !seq_busy && !cmd_valid;
  assign key_fire  = key_valid && key_ready;
  assign key_push  = key_fire && !key_drop;
  assign push_data = seq_push ? BW'(seq_data) : {key_release, key_code};

  kbd_lock_filter #(
    .CODE_W    (CODE_W),
    .NUM_LOCKS (2),
    .LOCK_CODES({CODE_W'(NUM_CODE), CODE_W'(CAPS_CODE)})
  ) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_fire   (key_fire),
    .ev_code   (key_code),
    .ev_release(key_release),
    .drop      (key_drop)
  );

  kbd_cmd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_data   (cmd_data),
    .tx_enable  (tx_enable),
    .kbd_disable(kbd_disable),
    .busy       (seq_busy),
    .flush      (seq_flush),
    .push       (seq_push),
    .push_data  (seq_data)
  );

  kbd_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(BW)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (seq_flush),
    .push     (seq_push || key_push),
    .push_data(push_data),
    .pop      (rx_pop),
    .avail    (rx_avail),
    .head     (rx_data)
  );

  a_r9_no_interleave: assert property (@(posedge clk) disable iff (!rst_n)
    seq_push |-> !key_push);
endmodule

// File: tb/kbd_cmd_encoder_bench.sv
module kbd_cmd_encoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CAPS = 119;
  localparam int NUML = 98;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_valid = 1'b0, key_release = 1'b0;
  logic [6:0] key_code = '0;
  logic       key_ready, cmd_ready, rx_avail;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_data = '0, rx_data;
  logic       tx_enable = 1'b1, kbd_disable = 1'b0, rx_pop = 1'b0;

  int n_checks = 0, n_fail = 0;
  logic [7:0] model [$];
  logic [1:0] caps_st = 2'b00, num_st = 2'b00;
  logic       m_led = 1'b0;

  kbd_cmd_encoder u_kbd_cmd_encoder (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_ready(key_ready),
    .key_code(key_code), .key_release(key_release), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .tx_enable(tx_enable),
    .kbd_disable(kbd_disable), .rx_avail(rx_avail), .rx_data(rx_data),
    .rx_pop(rx_pop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_key_byte(logic [6:0] c, logic rel);
    return {rel, c};
  endfunction

  function automatic logic [1:0] lock_next(logic [1:0] st, logic rel);
    return st ^ (rel ? 2'b10 : 2'b01);
  endfunction

  function automatic logic lock_drop(logic [1:0] nst, logic rel);
    return rel ? (nst == 2'b11) : (nst == 2'b10);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mpush(input logic [7:0] b);
    if (model.size() < 256) model.push_back(b);
  endtask

  task automatic send_key(input logic [6:0] c, input logic rel);
    logic [1:0] n;
    logic acc;
    @(negedge clk);
    key_valid = 1'b1; key_code = c; key_release = rel;
    acc = 1'b0;
    while (!acc) begin
      #1 acc = key_ready;
      @(posedge clk);
      @(negedge clk);
    end
    key_valid = 1'b0;
    if (c == 7'(CAPS)) begin
      n = lock_next(caps_st, rel); caps_st = n;
      if (!lock_drop(n, rel)) mpush(exp_key_byte(c, rel));
    end else if (c == 7'(NUML)) begin
      n = lock_next(num_st, rel); num_st = n;
      if (!lock_drop(n, rel)) mpush(exp_key_byte(c, rel));
    end else begin
      mpush(exp_key_byte(c, rel));
    end
  endtask

  task automatic model_cmd(input logic [7:0] d);
    if (!(tx_enable && !kbd_disable)) return;
    if (m_led) begin m_led = 1'b0; return; end
    case (d)
      8'h01: begin model.delete(); mpush(8'hFF); mpush(8'h04); mpush(8'h7F); end
      8'h0E: m_led = 1'b1;
      8'h07, 8'h0F: begin model.delete(); mpush(8'hFE); mpush(8'h21); end
      default: ;
    endcase
  endtask

  task automatic send_cmd(input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = d;
    #1 while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (4) @(posedge clk);
    model_cmd(d);
  endtask

  task automatic drain(input string req);
    while (model.size() > 0) begin
      @(negedge clk);
      check(req, {24'd0, rx_data}, {24'd0, model[0]});
      void'(model.pop_front());
      rx_pop = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rx_pop = 1'b0;
    end
    @(negedge clk);
    check({req, " R8 empty avail"}, {31'd0, rx_avail}, 32'd0);
    check({req, " R8 empty data"}, {24'd0, rx_data}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10 reset state
    @(negedge clk);
    check("R10 avail", {31'd0, rx_avail}, 32'd0);
    check("R10 data", {24'd0, rx_data}, 32'd0);
    check("R10 key_ready", {31'd0, key_ready}, 32'd1);
    check("R10 cmd_ready", {31'd0, cmd_ready}, 32'd1);

    // R1 press and release
    send_key(7'd5, 1'b0); send_key(7'd5, 1'b1); send_key(7'd127, 1'b1);
    drain("R1");

    // R2 lock toggle sequence
    send_key(7'(CAPS), 1'b0); send_key(7'(CAPS), 1'b1);
    send_key(7'(CAPS), 1'b0); send_key(7'(CAPS), 1'b1);
    send_key(7'(NUML), 1'b0); send_key(7'(NUML), 1'b1);
    drain("R2");

    // R3 reset reply flushes existing bytes
    send_key(7'd9, 1'b0);
    send_cmd(8'h01);
    drain("R3");

    // R5 both layout codes
    send_key(7'd10, 1'b0);
    send_cmd(8'h07);
    drain("R5 07");
    send_cmd(8'h0F);
    drain("R5 0F");

    // R4 parameter byte swallowed even if it is a reset code
    send_key(7'd11, 1'b0);
    send_cmd(8'h0E);
    send_cmd(8'h01);
    drain("R4 swallow");
    send_cmd(8'h07);
    drain("R4 after");

    // R6 unknown command
    send_key(7'd12, 1'b1);
    send_cmd(8'h55);
    send_cmd(8'h00);
    drain("R6");

    // R7 disabled paths
    send_key(7'd13, 1'b0);
    tx_enable = 1'b0;
    send_cmd(8'h01);
    tx_enable = 1'b1;
    kbd_disable = 1'b1;
    send_cmd(8'h0E);
    send_cmd(8'h07);
    kbd_disable = 1'b0;
    drain("R7");
    send_cmd(8'h0F);
    drain("R7 led untouched");

    // R9 command and key in the same cycle
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = 8'h01;
    key_valid = 1'b1; key_code = 7'd20; key_release = 1'b0;
    #1 check("R9 ready low with cmd", {31'd0, key_ready}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    #1 check("R9 ready low busy", {31'd0, key_ready}, 32'd0);
    begin
      logic acc = 1'b0;
      while (!acc) begin
        #1 acc = key_ready;
        @(posedge clk);
        @(negedge clk);
      end
    end
    key_valid = 1'b0;
    model.delete(); mpush(8'hFF); mpush(8'h04); mpush(8'h7F); mpush(8'd20);
    drain("R9 order");

    // R8 overflow and empty pop
    for (int i = 0; i < 260; i++) send_key(7'(i % 90), 1'b0);
    check("R8 model size", model.size(), 32'd256);
    drain("R8 overflow");
    @(negedge clk); rx_pop = 1'b1;
    @(posedge clk); @(negedge clk); rx_pop = 1'b0;
    check("R8 pop empty", {31'd0, rx_avail}, 32'd0);
    send_key(7'd33, 1'b0);
    drain("R8 after empty pop");

    // random phase, R1 and R2
    for (int i = 0; i < 400; i++) begin
      logic [6:0] c;
      int sel = $urandom_range(0, 3);
      c = (sel == 0) ? 7'(CAPS) : (sel == 1) ? 7'(NUML) : 7'($urandom_range(0, 127));
      send_key(c, 1'($urandom_range(0, 1)));
      if (i % 25 == 24) drain("R1 R2 random");
    end
    drain("R1 R2 random end");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule